// File: doc/BRIEF.md
# Auto-Restart Fault Timer

This block supervises a cycle-skipping power switcher. It counts cycles of the switching oscillator. It watches a single-bit indication that the regulation feedback has pulled the enable input low. Each such indication shows that the loop is still alive, so it clears the count.

If no feedback arrives for a whole run window, the block assumes a fault such as a shorted output or a broken loop. It then withdraws its switching permit for a longer rest window. After the rest window it grants switching again, and it keeps alternating between the two windows until feedback returns. A line under-voltage flag can freeze the rest-window count, which keeps the switch off for as long as the input line stays low. A second flag tells the block whether line sensing is fitted at all. When line sensing is absent, the under-voltage flag is ignored.

Both window lengths are given as oscillator cycle counts. At 130 kHz the defaults come to about 32 ms of run and 128 ms of rest, so the windows scale inversely with the oscillator frequency. A one-cycle restart pulse marks each return from rest, for test observation.

Top module: `ar_fault_timer`

## Requirements
- R1: A synchronous active-low reset puts the block in the run window with a cleared count: `switch_ok`=1 and `restart_pulse`=0 in the cycle after a reset edge.
- R2: With `en_low`=0 throughout, `switch_ok` stays 1 for exactly ON_CYCLES cycles after reset or after a restart, then goes to 0.
- R3: Without a freeze, the rest window keeps `switch_ok`=0 for exactly OFF_CYCLES cycles, after which `switch_ok` returns to 1.
- R4: `restart_pulse` is 1 for exactly the one cycle in which `switch_ok` first returns to 1 after a rest window, and it is 0 in every other cycle.
- R5: `en_low`=1 in any run-window cycle restarts the count, so `switch_ok` stays 1 for ON_CYCLES further cycles after the last cycle with `en_low`=1.
- R6: If `en_low`=1 in the final cycle of a run window, the clear wins over the expiry and the run window does not end.
- R7: `en_low` has no effect during the rest window, which still lasts OFF_CYCLES cycles.
- R8: While in the rest window with `line_uv`=1 and `line_sense_en`=1, the count halts and `switch_ok` stays 0. The rest window is lengthened by the number of frozen cycles.
- R9: With `line_sense_en`=0, `line_uv` is ignored and the rest window lasts OFF_CYCLES cycles.
- R10: `line_uv` has no effect in the run window. When the line drops, switching continues for the full run window and then stays off, with no restart, until `line_uv` returns to 0.
- R11: With feedback absent, the run and rest windows alternate repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching oscillator cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_low | input | 1 | 1 when feedback pulled the enable input low this cycle |
| line_uv | input | 1 | Line under-voltage present |
| line_sense_en | input | 1 | 1 when line sensing is fitted |
| switch_ok | output | 1 | Switching permitted |
| restart_pulse | output | 1 | One-cycle mark at the end of a rest window |

## Verification
The feedback clear and the run-window expiry can fall in the same cycle. The bench provokes this by driving `en_low` high in exactly the last cycle of a run window, and it requires that `switch_ok` stays high for another full window. A second collision occurs when an under-voltage freeze starts partway through a rest window. The bench judges this by counting the rest length as the nominal length plus the frozen cycles, with the restart pulse landing on the first permitted cycle.

// File: rtl/ar_pkg.sv
// Shared types for the auto-restart fault timer.
package ar_pkg;
    // Window currently timed: run (switching allowed) or rest (blocked)
    typedef enum logic {AR_RUN = 1'b0, AR_REST = 1'b1} ar_mode_t;
endpackage

// File: rtl/ar_cycle_counter.sv
// Window cycle counter.
// Counts oscillator cycles up to a supplied terminal value. It clears on
// request, halts on request (clear has priority), and reports the cycle in
// which it rolls over from the terminal value back to zero.
// Assumes last_val stays stable while a window is being timed.
module ar_cycle_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [CNT_W-1:0] last_val,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    // Rollover happens only when neither clear nor hold is active
    assign wrap = (cnt_q == last_val) && !clr && !hold;

    // Count register: clear, hold, roll over or advance
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (hold)   cnt_q <= cnt_q;
        else if (wrap)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ar_window_fsm.sv
// Run/rest window sequencer.
// Toggles between the run and rest windows on each counter rollover, and
// emits a one-cycle restart mark when it returns from rest to run.
// Assumes wrap is a single-cycle event per window.
module ar_window_fsm
    import ar_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wrap,
    output ar_mode_t mode,
    output logic     restart
);
    ar_mode_t mode_q;
    logic     restart_q;

    // Mode register: flip the window on every rollover
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= AR_RUN;
        else if (wrap) mode_q <= (mode_q == AR_RUN) ? AR_REST : AR_RUN;
    end

    // Restart mark: set for the first cycle of a run window that follows rest
    always_ff @(posedge clk) begin
        if (!rst_n) restart_q <= 1'b0;
        else        restart_q <= wrap && (mode_q == AR_REST);
    end

    assign mode    = mode_q;
    assign restart = restart_q;
endmodule

// File: rtl/ar_fault_timer.sv
// Auto-restart fault timer (top).
// Grants switching during a run window that feedback activity keeps
// extending. When the run window expires it blocks switching for a rest
// window, which a qualified line under-voltage flag can freeze.
// Assumes all inputs are synchronous to the oscillator cycle clock.
module ar_fault_timer
    import ar_pkg::*;
#(
    parameter int ON_CYCLES  = 4160,
    parameter int OFF_CYCLES = 16640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_low,
    input  logic line_uv,
    input  logic line_sense_en,
    output logic switch_ok,
    output logic restart_pulse
);
    localparam int MAX_CYC = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYCLES - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYCLES - 1);

    ar_mode_t         mode;
    logic             wrap;
    logic             cnt_clr;
    logic             cnt_hold;
    logic [CNT_W-1:0] last_val;

    // Window control: feedback clears only the run window, and a qualified
    // under-voltage freezes only the rest window
    always_comb begin
        cnt_clr  = (mode == AR_RUN) && en_low;
        cnt_hold = (mode == AR_REST) && line_uv && line_sense_en;
        last_val = (mode == AR_RUN) ? ON_LAST : OFF_LAST;
    end

    ar_cycle_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .hold     (cnt_hold),
        .last_val (last_val),
        .wrap     (wrap)
    );

    ar_window_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .mode    (mode),
        .restart (restart_pulse)
    );

    assign switch_ok = (mode == AR_RUN);
endmodule

// File: rtl/ar_fault_timer_chk.sv
// Property checker for ar_fault_timer, attached by bind. It watches the
// ports only and keeps its own run-length counter for the window bound.
module ar_fault_timer_chk #(
    parameter int ON_CYCLES = 4160
) (
    input logic clk,
    input logic rst_n,
    input logic en_low,
    input logic line_uv,
    input logic line_sense_en,
    input logic switch_ok,
    input logic restart_pulse
);
    localparam int RUN_W = $clog2(ON_CYCLES + 2);
    logic [RUN_W-1:0] run_len;

    // Length of the current permitted stretch without feedback
    always_ff @(posedge clk) begin
        if (!rst_n || !switch_ok || en_low) run_len <= '0;
        else                                run_len <= run_len + 1'b1;
    end

    // R2
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUN_W'(ON_CYCLES));

    // R5
    feedback_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_ok && en_low) |=> switch_ok);

    // R8
    freeze_holds_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!switch_ok && line_uv && line_sense_en) |=> !switch_ok);

    // R4
    restart_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |-> switch_ok);

    // R4
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);
endmodule

bind ar_fault_timer ar_fault_timer_chk #(.ON_CYCLES(ON_CYCLES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_low        (en_low),
    .line_uv       (line_uv),
    .line_sense_en (line_sense_en),
    .switch_ok     (switch_ok),
    .restart_pulse (restart_pulse)
);

// File: tb/ar_fault_timer_tb_top.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor compares.
module ar_fault_timer_tb_top;
    localparam int ON  = 6;
    localparam int OFF = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, en_low = 1'b0, line_uv = 1'b0, line_sense_en = 1'b1;
    logic switch_ok, restart_pulse;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Requirement-level model state
    bit m_on = 1'b1;
    int m_cnt = 0;
    bit m_pulse = 1'b0;

    ar_fault_timer #(.ON_CYCLES(ON), .OFF_CYCLES(OFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_low(en_low), .line_uv(line_uv),
        .line_sense_en(line_sense_en), .switch_ok(switch_ok),
        .restart_pulse(restart_pulse)
    );

    // Driver: apply one cycle of stimulus and push the expected outcome
    task automatic cyc(input bit rs, input bit en, input bit uv, input bit se,
                       input string tag);
        @(negedge clk);
        rst_n = rs; en_low = en; line_uv = uv; line_sense_en = se;
        m_pulse = 1'b0;
        if (!rs) begin
            m_on = 1'b1; m_cnt = 0;
        end else if (m_on) begin
            if (en)                 m_cnt = 0;
            else if (m_cnt == ON-1) begin m_on = 1'b0; m_cnt = 0; end
            else                    m_cnt++;
        end else begin
            if (uv && se)            m_cnt = m_cnt;
            else if (m_cnt == OFF-1) begin m_on = 1'b1; m_cnt = 0; m_pulse = 1'b1; end
            else                     m_cnt++;
        end
        exp_q.push_back({m_on, m_pulse});
        tag_q.push_back(tag);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare after each edge, away from the edge itself
    always @(posedge clk) begin
        logic [1:0] e_v;
        string t_v;
        #2;
        if (exp_q.size() > 0) begin
            e_v = exp_q.pop_front();
            t_v = tag_q.pop_front();
            n_chk++;
            if ({switch_ok, restart_pulse} !== e_v) begin
                n_fail++;
                $display("FAIL %s: actual ok/pulse=%b%b expected=%b%b at %0t",
                         t_v, switch_ok, restart_pulse, e_v[1], e_v[0], $time);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) cyc(0, 0, 0, 1, "R1");
        // R2, R3, R4 windows and restart mark; R11 repetition
        repeat (ON)  cyc(1, 0, 0, 1, "R2");
        repeat (OFF) cyc(1, 0, 0, 1, "R3");
        cyc(1, 0, 0, 1, "R4");
        repeat (2*(ON+OFF)) cyc(1, 0, 0, 1, "R11");
        // R5 periodic feedback keeps the run window open
        repeat (2) cyc(0, 0, 0, 1, "R1");
        for (int i = 0; i < 30; i++) cyc(1, (i % 3) == 0, 0, 1, "R5");
        repeat (ON+2) cyc(1, 0, 0, 1, "R5");
        // R6 feedback in the final run cycle beats expiry
        repeat (2) cyc(0, 0, 0, 1, "R1");
        repeat (ON-1) cyc(1, 0, 0, 1, "R6");
        cyc(1, 1, 0, 1, "R6");
        repeat (ON+1) cyc(1, 0, 0, 1, "R6");
        // R7 feedback ignored in the rest window
        repeat (2) cyc(0, 0, 0, 1, "R1");
        repeat (ON)  cyc(1, 0, 0, 1, "R7");
        repeat (OFF) cyc(1, 1, 0, 1, "R7");
        repeat (2)   cyc(1, 0, 0, 1, "R7");
        // R8 freeze mid rest window
        repeat (2) cyc(0, 0, 0, 1, "R1");
        repeat (ON+4) cyc(1, 0, 0, 1, "R8");
        repeat (10)   cyc(1, 0, 1, 1, "R8");
        repeat (OFF)  cyc(1, 0, 0, 1, "R8");
        // R9 under-voltage ignored without line sensing
        repeat (2) cyc(0, 0, 0, 1, "R1");
        repeat (ON)    cyc(1, 0, 0, 0, "R9");
        repeat (OFF+2) cyc(1, 0, 1, 0, "R9");
        // R10 power-down: full run window, then held off until the line returns
        repeat (2) cyc(0, 0, 0, 1, "R1");
        repeat (ON)     cyc(1, 0, 1, 1, "R10");
        repeat (OFF+20) cyc(1, 0, 1, 1, "R10");
        repeat (OFF+2)  cyc(1, 0, 0, 1, "R10");
        repeat (2) @(negedge clk);
        report();
    end
endmodule